// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block is a bus master that reaches external program memory and external data memory, each with a 16-bit address space. The low address byte and the data byte share one 8-bit bus: the address goes out first, qualified by an active-high address latch pulse. The high address byte is driven on a separate 8-bit port for the whole transfer. An active-low select line marks a transfer as data memory; when it is high, the transfer goes to program memory. The strobes for read and write are active low.

A core asks for a transfer with a one-cycle start pulse. The pulse carries the address, the write data, the direction and the memory space. The block latches these, runs the phases on the bus and returns a one-cycle done pulse. For a read it also returns the captured byte. Parameters set the length of each phase in system clock cycles. A wait input can stretch the strobe one cycle at a time. The bidirectional pad is split into an output value, an output enable and an input value, and the pad itself lies outside this block.

Top module: `xmem_mux_bus`

## Requirements
- R1: While reset is low and after it, with no request pending: latch low, both strobes high, select high, bus enable low, busy low, done low.
- R2: A transfer opens with the latch high for exactly ALE_CYC cycles, with the address low byte driven on the shared bus. The high port shows the address high byte and holds it steady for the whole transfer.
- R3: The read strobe (low = active) is low for RD_CYC cycles on a read, and the write strobe for WR_CYC cycles on a write, when wait stays low. The other strobe stays high, and the latch is never high while a strobe is low. RD_CYC must exceed WR_CYC.
- R4: After the latch falls, the low address byte stays driven for AHOLD_CYC cycles. A strobe falls exactly AHOLD_CYC+SETUP_CYC cycles after the latch falls, never while the latch is high.
- R5: On a read, the shared bus is not driven during the SETUP_CYC cycles before the strobe or during the strobe. The returned byte is the bus input value in the last strobe cycle, that is, at the edge where the read strobe rises.
- R6: On a write, the data byte is driven for SETUP_CYC cycles before the strobe falls, during the strobe, and for HOLD_CYC cycles after it rises. It is the same value throughout.
- R7: The select is low for the data space and high for the program space. It is valid from the first latch cycle and unchanged until the transfer ends, which is after the strobe has risen.
- R8: Each strobe cycle in which wait is sampled high adds one cycle to the strobe.
- R9: Done is a one-cycle pulse. It appears ALE_CYC+AHOLD_CYC+SETUP_CYC+strobe length+HOLD_CYC+1 cycles after the edge that accepted the start.
- R10: Busy is high from the cycle after the start is accepted until done rises. A start while busy is ignored, and request inputs that change after the accepting edge do not affect the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_start | input | 1 | One-cycle transfer request |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Byte to write |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_space | input | 1 | 1 = data memory, 0 = program memory |
| req_rdata | output | 8 | Byte captured by the last read |
| req_done | output | 1 | One-cycle completion pulse |
| req_busy | output | 1 | Transfer in progress |
| bus_ad_out | output | 8 | Shared address/data bus, output value |
| bus_ad_oe | output | 1 | Shared bus output enable |
| bus_ad_in | input | 8 | Shared bus, input value |
| bus_ahi | output | 8 | High address byte port |
| bus_ale | output | 1 | Address latch pulse, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dm_n | output | 1 | Data memory select, active low |
| bus_wait | input | 1 | Strobe stretch request |

## Verification
The bench builds the block with ALE_CYC=2, AHOLD_CYC=1, SETUP_CYC=1, RD_CYC=4, WR_CYC=2 and HOLD_CYC=2. With these values every phase spans more than one cycle, and a start pulse can land inside a multi-cycle latch phase. Under this setup it sweeps six boundary addresses across both directions, both memory spaces and zero to two wait cycles, and computes each phase count, the latency and the read value arithmetically. The read bus value changes in every strobe cycle, so the exact capture edge can be seen in the returned byte.

// File: rtl/xmem_pkg.sv
// Package: shared phase encoding for the multiplexed external bus controller.
// Assumes: every phase of a transfer is visited in the listed order.
package xmem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ALE    = 3'd1,
        PH_AHOLD  = 3'd2,
        PH_SETUP  = 3'd3,
        PH_STROBE = 3'd4,
        PH_HOLD   = 3'd5
    } xmem_phase_e;

endpackage

// File: rtl/xmem_phase_timer.sv
// Module: down-counter that measures the length of one bus phase.
// Assumes: load values are at least 1; last_o is high when one cycle remains.
module xmem_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             freeze_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining cycles of the current phase; hold while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(1);
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (!freeze_i && (cnt_q > CNT_W'(1))) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Flag the final cycle of the phase.
    always_comb begin
        last_o = (cnt_q == CNT_W'(1));
    end

endmodule

// File: rtl/xmem_seq.sv
// Module: phase sequencer. It steps address-latch, address-hold, setup, strobe
// and hold phases, stretches the strobe on wait, and signals done and busy.
// Assumes: all phase lengths >= 1; is_write_i is stable from accept to end.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ALE_CYC   = 1,
    parameter int AHOLD_CYC = 1,
    parameter int SETUP_CYC = 1,
    parameter int RD_CYC    = 3,
    parameter int WR_CYC    = 2,
    parameter int HOLD_CYC  = 1,
    parameter int CNT_W     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        is_write_i,
    input  logic        wait_i,
    output xmem_phase_e phase_o,
    output logic        accept_o,
    output logic        strobe_end_o,
    output logic        done_o,
    output logic        busy_o
);

    localparam logic [CNT_W-1:0] ALE_LEN   = CNT_W'(ALE_CYC);
    localparam logic [CNT_W-1:0] AHOLD_LEN = CNT_W'(AHOLD_CYC);
    localparam logic [CNT_W-1:0] SETUP_LEN = CNT_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] RD_LEN    = CNT_W'(RD_CYC);
    localparam logic [CNT_W-1:0] WR_LEN    = CNT_W'(WR_CYC);
    localparam logic [CNT_W-1:0] HOLD_LEN  = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] ONE_LEN   = CNT_W'(1);

    xmem_phase_e      phase_q;
    xmem_phase_e      phase_d;
    logic [CNT_W-1:0] len_d;
    logic             last;
    logic             freeze;
    logic             advance;
    logic             done_q;

    // Decide acceptance, wait freeze and phase advance from the current phase.
    always_comb begin
        accept_o     = (phase_q == PH_IDLE) && start_i;
        freeze       = (phase_q == PH_STROBE) && wait_i;
        advance      = (phase_q != PH_IDLE) && last && !freeze;
        strobe_end_o = advance && (phase_q == PH_STROBE);
    end

    // Select the following phase and its length.
    always_comb begin
        case (phase_q)
            PH_IDLE: begin
                phase_d = PH_ALE;
                len_d   = ALE_LEN;
            end
            PH_ALE: begin
                phase_d = PH_AHOLD;
                len_d   = AHOLD_LEN;
            end
            PH_AHOLD: begin
                phase_d = PH_SETUP;
                len_d   = SETUP_LEN;
            end
            PH_SETUP: begin
                phase_d = PH_STROBE;
                len_d   = is_write_i ? WR_LEN : RD_LEN;
            end
            PH_STROBE: begin
                phase_d = PH_HOLD;
                len_d   = HOLD_LEN;
            end
            default: begin
                phase_d = PH_IDLE;
                len_d   = ONE_LEN;
            end
        endcase
    end

    xmem_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept_o || advance),
        .load_val_i (len_d),
        .freeze_i   (freeze),
        .last_o     (last)
    );

    // Move to the next phase at a request or at the end of a phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (accept_o || advance) begin
            phase_q <= phase_d;
        end
    end

    // Raise done for one cycle when the hold phase finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= advance && (phase_q == PH_HOLD);
        end
    end

    // Expose the phase and status.
    always_comb begin
        phase_o = phase_q;
        done_o  = done_q;
        busy_o  = (phase_q != PH_IDLE);
    end

endmodule

// File: rtl/xmem_bus_drive.sv
// Module: request latch and pin decoder. It holds the request from the
// accepting edge, drives the shared bus, high port, latch, strobes and select
// from the phase, and captures read data when the read strobe ends.
// Assumes: phase_i comes from xmem_seq; bus_ad_in_i is synchronous to clk.
module xmem_bus_drive
    import xmem_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              write_i,
    input  logic              data_space_i,
    input  xmem_phase_e       phase_i,
    input  logic              strobe_end_i,
    input  logic [BYTE_W-1:0] bus_ad_in_i,
    output logic              is_write_o,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [BYTE_W-1:0] bus_ad_out_o,
    output logic              bus_ad_oe_o,
    output logic [BYTE_W-1:0] bus_ahi_o,
    output logic              bus_ale_o,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o,
    output logic              bus_dm_n_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              write_q;
    logic              space_q;
    logic [BYTE_W-1:0] rdata_q;
    logic              addr_phase;
    logic              data_phase;

    // Latch the request fields on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            space_q <= 1'b0;
        end else if (accept_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            write_q <= write_i;
            space_q <= data_space_i;
        end
    end

    // Capture the read byte on the edge that ends the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (strobe_end_i && !write_q) begin
            rdata_q <= bus_ad_in_i;
        end
    end

    // Classify the phase as address-on-bus or data-on-bus.
    always_comb begin
        addr_phase = (phase_i == PH_ALE) || (phase_i == PH_AHOLD);
        data_phase = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) ||
                     (phase_i == PH_HOLD);
    end

    // Decode the bus pins from the phase and the latched request.
    always_comb begin
        bus_ale_o    = (phase_i == PH_ALE);
        bus_ad_oe_o  = addr_phase || (data_phase && write_q);
        if (addr_phase) begin
            bus_ad_out_o = addr_q[BYTE_W-1:0];
        end else if (data_phase && write_q) begin
            bus_ad_out_o = wdata_q;
        end else begin
            bus_ad_out_o = '0;
        end
        bus_ahi_o    = addr_q[ADDR_W-1:BYTE_W];
        bus_rd_n_o   = !((phase_i == PH_STROBE) && !write_q);
        bus_wr_n_o   = !((phase_i == PH_STROBE) && write_q);
        bus_dm_n_o   = !((phase_i != PH_IDLE) && space_q);
        is_write_o   = write_q;
        rdata_o      = rdata_q;
    end

endmodule

// File: rtl/xmem_mux_bus.sv
// Module: top of the multiplexed external memory bus controller.
// Assumes: phase lengths >= 1 and RD_CYC > WR_CYC; one transfer at a time.
module xmem_mux_bus
    import xmem_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int ALE_CYC   = 1,
    parameter int AHOLD_CYC = 1,
    parameter int SETUP_CYC = 1,
    parameter int RD_CYC    = 3,
    parameter int WR_CYC    = 2,
    parameter int HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [2*BYTE_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_data_space,
    output logic [BYTE_W-1:0] req_rdata,
    output logic              req_done,
    output logic              req_busy,
    output logic [BYTE_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [BYTE_W-1:0] bus_ad_in,
    output logic [BYTE_W-1:0] bus_ahi,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_dm_n,
    input  logic              bus_wait
);

    localparam int ADDR_W = 2 * BYTE_W;
    localparam int LEN_SUM = ALE_CYC + AHOLD_CYC + SETUP_CYC + RD_CYC +
                             WR_CYC + HOLD_CYC;
    localparam int CNT_W = $clog2(LEN_SUM + 1);

    xmem_phase_e phase;
    logic        accept;
    logic        strobe_end;
    logic        is_write;

    xmem_seq #(
        .ALE_CYC   (ALE_CYC),
        .AHOLD_CYC (AHOLD_CYC),
        .SETUP_CYC (SETUP_CYC),
        .RD_CYC    (RD_CYC),
        .WR_CYC    (WR_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (req_start),
        .is_write_i   (is_write),
        .wait_i       (bus_wait),
        .phase_o      (phase),
        .accept_o     (accept),
        .strobe_end_o (strobe_end),
        .done_o       (req_done),
        .busy_o       (req_busy)
    );

    xmem_bus_drive #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_drive (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .addr_i       (req_addr),
        .wdata_i      (req_wdata),
        .write_i      (req_write),
        .data_space_i (req_data_space),
        .phase_i      (phase),
        .strobe_end_i (strobe_end),
        .bus_ad_in_i  (bus_ad_in),
        .is_write_o   (is_write),
        .rdata_o      (req_rdata),
        .bus_ad_out_o (bus_ad_out),
        .bus_ad_oe_o  (bus_ad_oe),
        .bus_ahi_o    (bus_ahi),
        .bus_ale_o    (bus_ale),
        .bus_rd_n_o   (bus_rd_n),
        .bus_wr_n_o   (bus_wr_n),
        .bus_dm_n_o   (bus_dm_n)
    );

endmodule

// File: rtl/xmem_mux_bus_chk.sv
// Module: protocol checker for xmem_mux_bus, attached by bind.
// Assumes: reset is held low for at least one clock edge at start-up.
module xmem_mux_bus_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_done,
    input logic              req_busy,
    input logic [BYTE_W-1:0] bus_ad_out,
    input logic              bus_ad_oe,
    input logic [BYTE_W-1:0] bus_ahi,
    input logic              bus_ale,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_dm_n
);

    // R3: strobes never overlap each other or the latch pulse.
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !((!bus_rd_n && !bus_wr_n) || (bus_ale && (!bus_rd_n || !bus_wr_n))));

    // R4: the read strobe falls only after the latch has been low a cycle.
    a_r4_rd_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> (!bus_ale && !$past(bus_ale)));

    // R5: the shared bus is released while the read strobe is low.
    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe);

    // R6: write data is still driven, unchanged, when the write strobe rises.
    a_r6_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> (bus_ad_oe && $stable(bus_ad_out)));

    // R7: the select does not change within a transfer.
    a_r7_select_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && $past(req_busy)) |-> $stable(bus_dm_n));

    // R2: the high address port does not change within a transfer.
    a_r2_ahi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && $past(req_busy)) |-> $stable(bus_ahi));

    // R9: done lasts a single cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R10: busy is already low when done is reported.
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> !req_busy);

endmodule

bind xmem_mux_bus xmem_mux_bus_chk #(
    .BYTE_W (BYTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_done   (req_done),
    .req_busy   (req_busy),
    .bus_ad_out (bus_ad_out),
    .bus_ad_oe  (bus_ad_oe),
    .bus_ahi    (bus_ahi),
    .bus_ale    (bus_ale),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_dm_n   (bus_dm_n)
);

// File: tb/xmem_mux_bus_bench.sv
// Bench: sweeps addresses, directions, spaces and wait counts, and compares
// phase lengths, bus values and results with arithmetic expectations.
module xmem_mux_bus_bench;

    localparam int P_ALE = 2;
    localparam int P_AH  = 1;
    localparam int P_SU  = 1;
    localparam int P_RD  = 4;
    localparam int P_WR  = 2;
    localparam int P_HD  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_data_space = 1'b0;
    logic [7:0]  req_rdata;
    logic        req_done;
    logic        req_busy;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [7:0]  bus_ad_in = '0;
    logic [7:0]  bus_ahi;
    logic        bus_ale;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic        bus_dm_n;
    logic        bus_wait = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    xmem_mux_bus #(
        .BYTE_W    (8),
        .ALE_CYC   (P_ALE),
        .AHOLD_CYC (P_AH),
        .SETUP_CYC (P_SU),
        .RD_CYC    (P_RD),
        .WR_CYC    (P_WR),
        .HOLD_CYC  (P_HD)
    ) u_xmem_mux_bus (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_start      (req_start),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .req_write      (req_write),
        .req_data_space (req_data_space),
        .req_rdata      (req_rdata),
        .req_done       (req_done),
        .req_busy       (req_busy),
        .bus_ad_out     (bus_ad_out),
        .bus_ad_oe      (bus_ad_oe),
        .bus_ad_in      (bus_ad_in),
        .bus_ahi        (bus_ahi),
        .bus_ale        (bus_ale),
        .bus_rd_n       (bus_rd_n),
        .bus_wr_n       (bus_wr_n),
        .bus_dm_n       (bus_dm_n),
        .bus_wait       (bus_wait)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_val(input logic [15:0] a, input logic sp);
        return a[7:0] ^ a[15:8] ^ (sp ? 8'h5A : 8'hC3);
    endfunction

    task automatic run_xfer(input logic [15:0] a, input logic [7:0] wd,
                            input logic wr, input logic sp, input int k,
                            input logic ign);
        int n = 0;
        int ale_cnt = 0;
        int gap = 0;
        int stb = 0;
        int hold = 0;
        logic stb_low;
        logic [7:0] exp_rd;
        @(negedge clk);
        req_addr = a; req_wdata = wd; req_write = wr; req_data_space = sp;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        req_addr = ~a; req_wdata = ~wd; req_write = !wr; req_data_space = !sp;
        while (!req_done && n < 200) begin
            n++;
            req_start = (ign && n == 2);
            chk("R10 busy during transfer", int'(req_busy), 1);
            chk("R7 select level", int'(bus_dm_n), int'(!sp));
            chk("R2 high port", int'(bus_ahi), int'(a[15:8]));
            stb_low = wr ? !bus_wr_n : !bus_rd_n;
            chk("R3 other strobe idle", int'(wr ? bus_rd_n : bus_wr_n), 1);
            if (bus_ale) begin
                ale_cnt++;
                chk("R2 low byte on bus", int'(bus_ad_oe ? bus_ad_out : 8'hxx), int'(a[7:0]));
                chk("R3 no strobe with latch", int'(bus_rd_n & bus_wr_n), 1);
            end else if (stb_low) begin
                stb++;
                if (wr) chk("R6 data in strobe", int'(bus_ad_oe ? bus_ad_out : 8'hxx), int'(wd));
                else    chk("R5 bus released in strobe", int'(bus_ad_oe), 0);
                bus_wait  = (stb <= k);
                bus_ad_in = mem_val(a, sp) ^ 8'(stb);
            end else if (stb == 0) begin
                gap++;
                if (gap <= P_AH)
                    chk("R4 address hold", int'(bus_ad_oe ? bus_ad_out : 8'hxx), int'(a[7:0]));
                else if (wr)
                    chk("R6 data setup", int'(bus_ad_oe ? bus_ad_out : 8'hxx), int'(wd));
                else
                    chk("R5 bus released before strobe", int'(bus_ad_oe), 0);
            end else begin
                hold++;
                bus_wait = 1'b0;
                if (wr) chk("R6 data hold", int'(bus_ad_oe ? bus_ad_out : 8'hxx), int'(wd));
            end
            @(negedge clk);
        end
        req_start = 1'b0;
        bus_wait  = 1'b0;
        chk("R9 done seen", int'(req_done), 1);
        chk("R10 busy low at done", int'(req_busy), 0);
        chk("R2 latch width", ale_cnt, P_ALE);
        chk("R4 latch fall to strobe", gap, P_AH + P_SU);
        if (k == 0) chk("R3 strobe width", stb, wr ? P_WR : P_RD);
        else        chk("R8 stretched strobe width", stb, (wr ? P_WR : P_RD) + k);
        chk("R6 hold cycles", hold, P_HD);
        chk("R9 latency", n + 1, P_ALE + P_AH + P_SU + (wr ? P_WR : P_RD) + k + P_HD + 1);
        if (!wr) begin
            exp_rd = mem_val(a, sp) ^ 8'((wr ? P_WR : P_RD) + k);
            chk("R5 read byte", int'(req_rdata), int'(exp_rd));
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 done single pulse", int'(req_done), 0);
            chk("R10 no second transfer", int'(bus_ale | req_busy), 0);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, int'(bus_ale), 0);
        chk(req, int'(bus_rd_n & bus_wr_n & bus_dm_n), 1);
        chk(req, int'(bus_ad_oe), 0);
        chk(req, int'(req_busy | req_done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R9 watchdog: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] addrs [6];
        addrs[0] = 16'h0000; addrs[1] = 16'hFFFF; addrs[2] = 16'h12AB;
        addrs[3] = 16'h8001; addrs[4] = 16'h00FF; addrs[5] = 16'h7E3C;
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");
        for (int ai = 0; ai < 6; ai++)
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 3; k++)
                        run_xfer(addrs[ai], addrs[ai][7:0] + addrs[ai][15:8] + 8'(k),
                                 w[0], s[0], k, (k == 1));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule